// File: doc/BRIEF.md
# Real-Time Clock with Alarm and Event Interrupts

This peripheral keeps wall-clock time for a chip: a seconds field, a minutes field, an hours field and a free-running 32-bit day count. A prescaler divides the system clock down to a one-second tick. Software talks to the block over a simple 32-bit register bus. Reads are combinational from the address. A write takes effect on the clock edge that ends the cycle in which `bus_sel` and `bus_write` are both high. Only word-aligned, full-word accesses are decoded. An address whose two low bits are not zero behaves as unmapped.

The current time is read from read-only counter registers and from one packed word. It is changed through a separate group of write-only set registers. An hours/minutes/seconds alarm can be armed. Four rollover events (second, minute, hour, day) and the alarm latch into a status register that software clears by writing ones. Interrupts leave the block in two forms. The first is a level alarm line, qualified by the alarm enable. The second is five one-cycle pulses, one per event. Each pulse fires in the cycle its status bit becomes set.

The asynchronous active-low reset is released through a two-stage synchronizer. Internal state leaves reset two clock edges after `arst_n` rises.

Top module: `rtc_alarm_top`

## Requirements
- R1: While reset is applied, and after it is released, every counter, all three alarm fields, the control register and the status register read 0, and all six interrupt outputs are low.
- R2: Reading byte offset 0x3C returns 0x00010000. Any other offset not listed in R3–R9, a misaligned address, or a write-only set register reads as 0. Writes to such offsets change nothing. Writes to the read-only counter offsets also change nothing.
- R3: Control bit 0 enables counting. Every write of the control register (offset 0x20, low 6 bits kept, read back zero-extended) restarts the prescaler. With bit 0 set, the first tick therefore updates the time exactly CLKS_PER_SEC clock edges after the write edge, and further ticks follow every CLKS_PER_SEC edges. With bit 0 clear, the time does not advance.
- R4: On each tick, seconds (read at 0x00) increments. On reaching 60 it becomes 0 and carries into minutes (0x04). Minutes on reaching 60 becomes 0 and carries into hours (0x08). Hours on reaching 24 becomes 0 and increments the 32-bit day count (0x0C).
- R5: Writing 0x24, 0x28, 0x2C or 0x30 loads seconds, minutes, hours or days respectively. A load in the same cycle as a tick wins over the increment for that field.
- R6: Offset 0x44 reads the time packed as {days[14:0], hours[4:0], minutes[5:0], seconds[5:0]}, from bit 31 down to bit 0.
- R7: Status register (offset 0x34): bit 0 sets on a tick, bit 1 on a minute carry, bit 2 on an hour carry and bit 3 on a day carry. Each is set only when control bit 1, 2, 3 or 4 respectively is set.
- R8: The alarm fields are seconds at 0x10, minutes at 0x14 and hours at 0x18. They are read/write and keep 6, 6 and 5 bits. When control bit 5 is set, status bit 4 sets on a tick after which the new hours, minutes and seconds all equal the alarm fields.
- R9: Writing the status register clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R10: `irq_alarm_lvl` is high exactly while status bit 4 and control bit 5 are both set.
- R11: `pulse_sec`, `pulse_min`, `pulse_hour`, `pulse_day` and `pulse_alarm` each go high for one clock cycle, in the cycle in which status bit 0, 1, 2, 3 or 4 respectively becomes set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_write | input | 1 | Write qualifier for the access |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_alarm_lvl | output | 1 | Level alarm interrupt |
| pulse_alarm | output | 1 | One-cycle alarm event pulse |
| pulse_sec | output | 1 | One-cycle second event pulse |
| pulse_min | output | 1 | One-cycle minute event pulse |
| pulse_hour | output | 1 | One-cycle hour event pulse |
| pulse_day | output | 1 | One-cycle day event pulse |

## Verification
A prescaler phase off by one cycle shows up as a seconds value that is still old, or already new, when it is read one edge either side of the expected tick edge. A broken carry chain is exposed at the single tick that rolls 23:59:59 into the next day: it produces wrong counter reads, a wrong status value and missing minute, hour or day pulses in that cycle. A status bit that is stuck, or that is cleared by the wrong mask, appears on the next read of offset 0x34 and on the level alarm line. A lost set-over-tick priority appears on the first read after the colliding write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 32;

  localparam int SECS_PER_MIN  = 60;
  localparam int MINS_PER_HOUR = 60;
  localparam int HOURS_PER_DAY = 24;

  localparam int NUM_UNITS  = 4;
  localparam int NUM_EVENTS = NUM_UNITS + 1;
  localparam int EV_ALARM   = NUM_UNITS;
  localparam int CTRL_W     = NUM_EVENTS + 1;

  localparam int PACK_DAY_SH  = 17;
  localparam int PACK_HOUR_SH = 12;
  localparam int PACK_MIN_SH  = 6;

  localparam logic [31:0] REV_CODE = 32'h0001_0000;

  // word indices (byte offset / 4)
  localparam logic [5:0] IDX_SEC    = 6'h00;
  localparam logic [5:0] IDX_MIN    = 6'h01;
  localparam logic [5:0] IDX_HOUR   = 6'h02;
  localparam logic [5:0] IDX_DAY    = 6'h03;
  localparam logic [5:0] IDX_A_SEC  = 6'h04;
  localparam logic [5:0] IDX_A_MIN  = 6'h05;
  localparam logic [5:0] IDX_A_HOUR = 6'h06;
  localparam logic [5:0] IDX_CTRL   = 6'h08;
  localparam logic [5:0] IDX_S_SEC  = 6'h09;
  localparam logic [5:0] IDX_S_MIN  = 6'h0A;
  localparam logic [5:0] IDX_S_HOUR = 6'h0B;
  localparam logic [5:0] IDX_S_DAY  = 6'h0C;
  localparam logic [5:0] IDX_STAT   = 6'h0D;
  localparam logic [5:0] IDX_REV    = 6'h0F;
  localparam logic [5:0] IDX_PACK   = 6'h11;

  typedef struct packed {
    logic [HOUR_W-1:0] hours;
    logic [MIN_W-1:0]  mins;
    logic [SEC_W-1:0]  secs;
  } rtc_hms_t;

  typedef struct packed {
    logic [DAY_W-1:0] days;
    rtc_hms_t         hms;
  } rtc_time_t;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CLKS_PER_SEC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick   = run_en && !restart && (cnt_q == LAST);
  assign cnt_en = restart || run_en;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [NUM_UNITS-1:0] set_wr,
  input  logic [31:0]          set_data,
  output rtc_time_t            time_q,
  output rtc_time_t            time_d,
  output logic [NUM_UNITS-1:0] roll
);
  logic [SEC_W:0]  sec_inc;
  logic [MIN_W:0]  min_inc;
  logic [HOUR_W:0] hour_inc;
  logic            time_en;

  assign sec_inc  = {1'b0, time_q.hms.secs}  + 1'b1;
  assign min_inc  = {1'b0, time_q.hms.mins}  + 1'b1;
  assign hour_inc = {1'b0, time_q.hms.hours} + 1'b1;
  assign time_en  = tick || (|set_wr);

  always_comb begin
    time_d = time_q;
    roll   = '0;
    if (tick) begin
      roll[0] = 1'b1;
      if (sec_inc >= (SEC_W+1)'(SECS_PER_MIN)) begin
        time_d.hms.secs = '0;
        roll[1] = 1'b1;
        if (min_inc >= (MIN_W+1)'(MINS_PER_HOUR)) begin
          time_d.hms.mins = '0;
          roll[2] = 1'b1;
          if (hour_inc >= (HOUR_W+1)'(HOURS_PER_DAY)) begin
            time_d.hms.hours = '0;
            roll[3] = 1'b1;
            time_d.days = time_q.days + 1'b1;
          end else begin
            time_d.hms.hours = hour_inc[HOUR_W-1:0];
          end
        end else begin
          time_d.hms.mins = min_inc[MIN_W-1:0];
        end
      end else begin
        time_d.hms.secs = sec_inc[SEC_W-1:0];
      end
    end
    if (set_wr[0]) time_d.hms.secs  = set_data[SEC_W-1:0];
    if (set_wr[1]) time_d.hms.mins  = set_data[MIN_W-1:0];
    if (set_wr[2]) time_d.hms.hours = set_data[HOUR_W-1:0];
    if (set_wr[3]) time_d.days      = set_data[DAY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (time_en) time_q <= time_d;
  end
endmodule

// File: rtl/rtc_event_unit.sv
module rtc_event_unit
  import rtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [NUM_UNITS-1:0]  roll,
  input  logic [NUM_EVENTS-1:0] ev_en,
  input  rtc_hms_t              time_next,
  input  rtc_hms_t              alarm,
  input  logic                  clr_wr,
  input  logic [NUM_EVENTS-1:0] clr_mask,
  output logic [NUM_EVENTS-1:0] status_q,
  output logic [NUM_EVENTS-1:0] ev_set,
  output logic [NUM_EVENTS-1:0] pulse_q,
  output logic                  alarm_lvl
);
  logic [NUM_EVENTS-1:0] status_d;
  logic [NUM_EVENTS-1:0] clr_bits;
  logic                  status_en;
  logic                  alarm_match;

  assign alarm_match = (time_next == alarm);

  always_comb begin
    ev_set = '0;
    ev_set[NUM_UNITS-1:0] = roll & ev_en[NUM_UNITS-1:0];
    ev_set[EV_ALARM]      = tick && ev_en[EV_ALARM] && alarm_match;
  end

  assign clr_bits  = clr_wr ? clr_mask : '0;
  assign status_d  = (status_q & ~clr_bits) | ev_set;
  assign status_en = clr_wr || (|ev_set);
  assign alarm_lvl = status_q[EV_ALARM] && ev_en[EV_ALARM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  generate
    for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q[g] <= 1'b0;
        else        pulse_q[g] <= ev_set[g];
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_pkg::*;
#(
  parameter int CLKS_PER_SEC = 1000,
  parameter int RST_STAGES   = 2
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        bus_sel,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_alarm_lvl,
  output logic        pulse_alarm,
  output logic        pulse_sec,
  output logic        pulse_min,
  output logic        pulse_hour,
  output logic        pulse_day
);
  logic                  rst_n_sync;
  logic                  aligned;
  logic [5:0]            word_idx;
  logic                  wr_any;
  logic                  wr_ctrl, wr_stat, wr_a_sec, wr_a_min, wr_a_hour;
  logic [NUM_UNITS-1:0]  set_wr;
  logic [CTRL_W-1:0]     ctrl_q, ctrl_d;
  rtc_hms_t              alarm_q, alarm_d;
  logic                  alarm_en;
  logic                  tick;
  rtc_time_t             time_q, time_d;
  logic [NUM_UNITS-1:0]  roll;
  logic [NUM_EVENTS-1:0] status_q, ev_set, pulse_q;
  logic [31:0]           pack_word;

  rtc_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n_sync)
  );

  // bus decode
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign word_idx = bus_addr[7:2];
  assign wr_any   = bus_sel && bus_write && aligned;

  assign wr_ctrl   = wr_any && (word_idx == IDX_CTRL);
  assign wr_stat   = wr_any && (word_idx == IDX_STAT);
  assign wr_a_sec  = wr_any && (word_idx == IDX_A_SEC);
  assign wr_a_min  = wr_any && (word_idx == IDX_A_MIN);
  assign wr_a_hour = wr_any && (word_idx == IDX_A_HOUR);
  assign set_wr[0] = wr_any && (word_idx == IDX_S_SEC);
  assign set_wr[1] = wr_any && (word_idx == IDX_S_MIN);
  assign set_wr[2] = wr_any && (word_idx == IDX_S_HOUR);
  assign set_wr[3] = wr_any && (word_idx == IDX_S_DAY);

  // control and alarm registers: next state
  always_comb begin
    ctrl_d  = ctrl_q;
    alarm_d = alarm_q;
    if (wr_ctrl)   ctrl_d        = bus_wdata[CTRL_W-1:0];
    if (wr_a_sec)  alarm_d.secs  = bus_wdata[SEC_W-1:0];
    if (wr_a_min)  alarm_d.mins  = bus_wdata[MIN_W-1:0];
    if (wr_a_hour) alarm_d.hours = bus_wdata[HOUR_W-1:0];
  end

  assign alarm_en = wr_a_sec || wr_a_min || wr_a_hour;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)   alarm_q <= '0;
    else if (alarm_en) alarm_q <= alarm_d;
  end

  rtc_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC)) presc_i (
    .clk(clk), .rst_n(rst_n_sync), .run_en(ctrl_q[0]),
    .restart(wr_ctrl), .tick(tick)
  );

  rtc_time_counter time_i (
    .clk(clk), .rst_n(rst_n_sync), .tick(tick), .set_wr(set_wr),
    .set_data(bus_wdata), .time_q(time_q), .time_d(time_d), .roll(roll)
  );

  rtc_event_unit event_i (
    .clk(clk), .rst_n(rst_n_sync), .tick(tick), .roll(roll),
    .ev_en(ctrl_q[CTRL_W-1:1]), .time_next(time_d.hms), .alarm(alarm_q),
    .clr_wr(wr_stat), .clr_mask(bus_wdata[NUM_EVENTS-1:0]),
    .status_q(status_q), .ev_set(ev_set), .pulse_q(pulse_q),
    .alarm_lvl(irq_alarm_lvl)
  );

  assign pulse_sec   = pulse_q[0];
  assign pulse_min   = pulse_q[1];
  assign pulse_hour  = pulse_q[2];
  assign pulse_day   = pulse_q[3];
  assign pulse_alarm = pulse_q[EV_ALARM];

  assign pack_word = (time_q.days << PACK_DAY_SH)
                   | (32'(time_q.hms.hours) << PACK_HOUR_SH)
                   | (32'(time_q.hms.mins)  << PACK_MIN_SH)
                   |  32'(time_q.hms.secs);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word_idx)
        IDX_SEC:    bus_rdata = 32'(time_q.hms.secs);
        IDX_MIN:    bus_rdata = 32'(time_q.hms.mins);
        IDX_HOUR:   bus_rdata = 32'(time_q.hms.hours);
        IDX_DAY:    bus_rdata = time_q.days;
        IDX_A_SEC:  bus_rdata = 32'(alarm_q.secs);
        IDX_A_MIN:  bus_rdata = 32'(alarm_q.mins);
        IDX_A_HOUR: bus_rdata = 32'(alarm_q.hours);
        IDX_CTRL:   bus_rdata = 32'(ctrl_q);
        IDX_STAT:   bus_rdata = 32'(status_q);
        IDX_REV:    bus_rdata = REV_CODE;
        IDX_PACK:   bus_rdata = pack_word;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        ctrl_run,
  input logic        ctrl_alarm,
  input logic        set_sec_wr,
  input logic [5:0]  sec_q,
  input logic        clr_wr,
  input logic        clr_bit0,
  input logic        set_bit0,
  input logic        status0,
  input logic        pulse_sec,
  input logic        pulse_alarm,
  input logic        irq_alarm_lvl,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_rdata
);
  assert_stop_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_run |-> !tick);

  assert_sec_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !set_sec_wr) |=> (sec_q != $past(sec_q)));

  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bit0 && !set_bit0) |=> !status0);

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_sec |=> !pulse_sec);

  assert_alarm_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_alarm && ctrl_alarm) |-> irq_alarm_lvl);

  assert_rev_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h3C) |-> (bus_rdata == 32'h0001_0000));
endmodule

bind rtc_alarm_top rtc_alarm_chk chk_i (
  .clk(clk), .rst_n(rst_n_sync), .tick(tick), .ctrl_run(ctrl_q[0]),
  .ctrl_alarm(ctrl_q[5]), .set_sec_wr(set_wr[0]), .sec_q(time_q.hms.secs),
  .clr_wr(wr_stat), .clr_bit0(bus_wdata[0]), .set_bit0(ev_set[0]),
  .status0(status_q[0]), .pulse_sec(pulse_sec), .pulse_alarm(pulse_alarm),
  .irq_alarm_lvl(irq_alarm_lvl), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/rtc_alarm_top_tb_top.sv
module rtc_alarm_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk;
  logic        arst_n;
  logic        bus_sel, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_alarm_lvl, pulse_alarm, pulse_sec, pulse_min, pulse_hour, pulse_day;

  int n_checks = 0;
  int n_errors = 0;
  int cnt_sec = 0, cnt_min = 0, cnt_hour = 0, cnt_day = 0, cnt_alarm = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  rtc_alarm_top #(.CLKS_PER_SEC(N)) dut_i (
    .clk(clk), .arst_n(arst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_alarm_lvl(irq_alarm_lvl), .pulse_alarm(pulse_alarm),
    .pulse_sec(pulse_sec), .pulse_min(pulse_min), .pulse_hour(pulse_hour),
    .pulse_day(pulse_day)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: read-data scoreboard and pulse counters
  always @(negedge clk) begin
    if (pulse_sec)   cnt_sec++;
    if (pulse_min)   cnt_min++;
    if (pulse_hour)  cnt_hour++;
    if (pulse_day)   cnt_day++;
    if (pulse_alarm) cnt_alarm++;
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (bus_rdata !== it.exp) begin
        n_errors++;
        $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                 it.tag, it.addr, bus_rdata, it.exp);
      end
    end
  end

  task automatic exp_read(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    sb_item_t it;
    bus_addr = addr;
    it.addr = addr; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [31:0] data);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = addr; bus_wdata = data;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int d, input int h, input int m, input int s);
    return (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    arst_n = 1'b0; bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    exp_read(8'h00, 0, "R1 sec");
    exp_read(8'h04, 0, "R1 min");
    exp_read(8'h08, 0, "R1 hour");
    exp_read(8'h0C, 0, "R1 day");
    exp_read(8'h10, 0, "R1 alarm sec");
    exp_read(8'h20, 0, "R1 ctrl");
    exp_read(8'h34, 0, "R1 status");
    check_val("R1 outputs", {26'd0, irq_alarm_lvl, pulse_alarm, pulse_sec,
              pulse_min, pulse_hour, pulse_day}, 0);
    // R2 constants and unmapped
    exp_read(8'h3C, 32'h0001_0000, "R2 revision");
    exp_read(8'h40, 0, "R2 unmapped");
    exp_read(8'h24, 0, "R2 write-only reads zero");

    // R3 tick timing, R7 second event, R11 pulse
    do_write(8'h20, 32'h1F);
    repeat (N-1) @(posedge clk);
    #1;
    exp_read(8'h00, 0, "R3 no tick before interval");
    @(posedge clk); #1;
    exp_read(8'h00, 1, "R3 first tick after interval");
    exp_read(8'h34, 32'h01, "R7 second event");
    check_val("R11 one sec pulse", cnt_sec, 1);
    do_write(8'h20, 32'h1E);

    // R9 write-one-to-clear
    do_write(8'h34, 32'h0);
    exp_read(8'h34, 32'h01, "R9 zero write keeps");
    do_write(8'h34, 32'h1);
    exp_read(8'h34, 32'h00, "R9 one write clears");

    // R3 stopped
    repeat (3*N) @(posedge clk);
    #1;
    exp_read(8'h00, 1, "R3 stopped no advance");

    // R5 time set, R6 packed
    do_write(8'h24, 59);
    do_write(8'h28, 59);
    do_write(8'h2C, 23);
    do_write(8'h30, 5);
    exp_read(8'h00, 59, "R5 set sec");
    exp_read(8'h04, 59, "R5 set min");
    exp_read(8'h08, 23, "R5 set hour");
    exp_read(8'h0C, 5,  "R5 set day");
    exp_read(8'h44, pack(5, 23, 59, 59), "R6 packed");

    // R2 ignored writes
    do_write(8'h00, 7);
    do_write(8'h40, 32'hFFFF_FFFF);
    do_write(8'h12, 32'h3);
    exp_read(8'h00, 59, "R2 read-only write ignored");
    exp_read(8'h20, 32'h1E, "R2 ctrl untouched");
    exp_read(8'h10, 0, "R2 misaligned write ignored");

    // R4 full rollover, R7 events, R11 pulses
    do_write(8'h20, 32'h1F);
    repeat (N) @(posedge clk);
    #1;
    exp_read(8'h00, 0, "R4 sec wrap");
    exp_read(8'h04, 0, "R4 min wrap");
    exp_read(8'h08, 0, "R4 hour wrap");
    exp_read(8'h0C, 6, "R4 day increment");
    exp_read(8'h34, 32'h0F, "R7 all unit events");
    check_val("R11 min pulse", cnt_min, 1);
    check_val("R11 hour pulse", cnt_hour, 1);
    check_val("R11 day pulse", cnt_day, 1);
    do_write(8'h20, 32'h00);
    do_write(8'h34, 32'h1F);
    exp_read(8'h34, 0, "R9 clear all");

    // R8 alarm, R10 level
    do_write(8'h10, 3);
    do_write(8'h14, 0);
    do_write(8'h18, 0);
    exp_read(8'h10, 3, "R8 alarm sec readback");
    do_write(8'h20, 32'h21);
    repeat (3*N-1) @(posedge clk);
    #1;
    exp_read(8'h34, 0, "R8 no alarm before match");
    check_val("R10 level low before match", irq_alarm_lvl, 0);
    @(posedge clk); #1;
    exp_read(8'h34, 32'h10, "R8 alarm match, R7 gated sec");
    check_val("R10 level high", irq_alarm_lvl, 1);
    check_val("R11 alarm pulse", cnt_alarm, 1);
    check_val("R11 no sec pulse when gated", cnt_sec, 2);
    do_write(8'h20, 32'h01);
    check_val("R10 level follows enable", irq_alarm_lvl, 0);
    exp_read(8'h34, 32'h10, "R10 status kept");
    do_write(8'h34, 32'h10);
    exp_read(8'h34, 0, "R9 alarm cleared");

    // R5 set-over-tick priority
    do_write(8'h20, 32'h01);
    repeat (N-1) @(posedge clk);
    #1;
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 8'h24; bus_wdata = 40;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_write = 1'b0;
    exp_read(8'h00, 40, "R5 set wins over tick");
    repeat (N) @(posedge clk);
    #1;
    exp_read(8'h00, 41, "R5 counts from set value");

    // R1 reset mid-run
    arst_n = 1'b0;
    #1;
    exp_read(8'h10, 0, "R1 alarm cleared by reset");
    exp_read(8'h00, 0, "R1 sec cleared by reset");
    exp_read(8'h0C, 0, "R1 day cleared by reset");
    exp_read(8'h20, 0, "R1 ctrl cleared by reset");
    arst_n = 1'b1;
    repeat (3) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule